// File: doc/BRIEF.md
# Indirect Buffer-Array Readout Port

This block lets a host read back the contents of a two-bank buffer array through three registers: a control register, a data register and an ECC register. Each array entry is a data word paired with its ECC bits. The host writes the control register to choose a bank, set the entry to start from, and enable or disable stepping. It then reads data and ECC for the current entry. Reading the data register never moves the pointer. With stepping enabled, reading the ECC register moves the pointer to the next entry. A host that reads data and then ECC in turn therefore walks through consecutive entries.

The pointer returns to 0 on its own after the last entry of the full array. A host that uses only a smaller leading region must return to the start itself, by writing the control register again with address 0. The array has a separate preload port for test use. Error-code generation and any compare logic sit outside this block.

Top module: `bufrd_port`

## Requirements
- R1: After reset the pointer is 0, a control-register read returns 0 and `host_rdata` is 0.
- R2: A control write (offset 0) loads the pointer from bits [AW-1:0] of the written word at the next clock edge. A control read returns the last written word with bits [AW-1:0] replaced by the live pointer.
- R3: A data read (offset 1) returns the data word of the current entry in the selected bank and leaves the pointer unchanged.
- R4: When the auto-step bit (bit 8 of the control word) is 1, an ECC read (offset 2) returns the entry's ECC in bits [ECC_W-1:0], with zeros above, and advances the pointer by one.
- R5: When the auto-step bit is 0, an ECC read returns the ECC and leaves the pointer unchanged.
- R6: An advance from entry DEPTH-1 moves the pointer to 0.
- R7: The bank-select bit (bit 12 of the control word) chooses bank 0 or bank 1 for data and ECC reads. Bit 9 is the ECC-generate mode bit and is stored only.
- R8: `host_rdata` is updated at the clock edge that samples a read strobe and holds its value in every other cycle.
- R9: Writes to offsets 1 and 2 change neither the pointer nor the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe; takes priority over host_rd |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register offset: 0 control, 1 data, 2 ECC |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| tp_we | input | 1 | Test preload write enable |
| tp_bank | input | 1 | Test preload bank |
| tp_addr | input | AW | Test preload entry index |
| tp_data | input | DATA_W | Test preload data word |
| tp_ecc | input | ECC_W | Test preload ECC bits |

## Verification
Every read result appears on `host_rdata` one clock edge after the strobe is sampled. The pointer update from a control write or an ECC read takes effect at that same edge. The bench therefore drives each strobe at a falling edge and samples `host_rdata` at the next falling edge. It observes the pointer only through a later control read, so each pointer result is seen exactly one access after the access that caused it. Preload writes also take effect at the next edge, and the bench completes all of them before the first host access.

// File: rtl/bufrd_pkg.sv
package bufrd_pkg;
    // Host register offsets
    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_DATA = 2'd1;
    localparam logic [1:0] OFF_ECC  = 2'd2;

    // Control-word bit positions (address field sits in [AW-1:0])
    localparam int CTRL_STEP_BIT = 8;
    localparam int CTRL_EGEN_BIT = 9;
    localparam int CTRL_BANK_BIT = 12;

    typedef struct packed {
        logic ctrl_we;
        logic ctrl_re;
        logic data_re;
        logic ecc_re;
        logic any_re;
    } acc_t;
endpackage

// File: rtl/bufrd_decode.sv
module bufrd_decode
    import bufrd_pkg::*;
(
    input  logic       wr,
    input  logic       rd,
    input  logic [1:0] addr,
    output acc_t       acc
);
    logic rd_fire;

    always_comb begin
        rd_fire     = rd & ~wr;
        acc.ctrl_we = wr & (addr == OFF_CTRL);
        acc.ctrl_re = rd_fire & (addr == OFF_CTRL);
        acc.data_re = rd_fire & (addr == OFF_DATA);
        acc.ecc_re  = rd_fire & (addr == OFF_ECC);
        acc.any_re  = rd_fire;
    end
endmodule

// File: rtl/bufrd_ptr.sv
module bufrd_ptr #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] cur,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_comb begin
        if (load_en)
            nxt = load_val;
        else if (step_en)
            nxt = (cur == LAST) ? '0 : cur + AW'(1);
        else
            nxt = cur;
    end
endmodule

// File: rtl/bufrd_array.sv
module bufrd_array #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int WW = DATA_W + ECC_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              we_bank,
    input  logic [AW-1:0]     we_addr,
    input  logic [WW-1:0]     we_word,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [WW-1:0]     rd_word
);
    logic [WW-1:0] bank_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WW-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (we_bank == 1'(b)))
                mem_q[we_addr] <= we_word;
        end

        assign bank_word[b] = mem_q[rd_addr];
    end

    assign rd_word = rd_bank ? bank_word[1] : bank_word[0];
endmodule

// File: rtl/bufrd_port.sv
module bufrd_port
    import bufrd_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              tp_we,
    input  logic              tp_bank,
    input  logic [AW-1:0]     tp_addr,
    input  logic [DATA_W-1:0] tp_data,
    input  logic [ECC_W-1:0]  tp_ecc
);
    localparam int WW = DATA_W + ECC_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [AW-1:0]     ptr;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    acc_t              acc;
    logic [AW-1:0]     ptr_cur;
    logic [AW-1:0]     ptr_nxt;
    logic              step_cur;
    logic              bank_cur;
    logic [WW-1:0]     entry;
    logic [DATA_W-1:0] ctrl_view;

    assign ptr_cur  = st_q.ptr;
    assign step_cur = st_q.ctrl[CTRL_STEP_BIT];
    assign bank_cur = st_q.ctrl[CTRL_BANK_BIT];

    bufrd_decode u_dec (
        .wr   (host_wr),
        .rd   (host_rd),
        .addr (host_addr),
        .acc  (acc)
    );

    bufrd_ptr #(.DEPTH(DEPTH)) u_ptr (
        .cur      (ptr_cur),
        .load_en  (acc.ctrl_we),
        .load_val (host_wdata[AW-1:0]),
        .step_en  (acc.ecc_re & step_cur),
        .nxt      (ptr_nxt)
    );

    bufrd_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ECC_W(ECC_W)) u_arr (
        .clk     (clk),
        .we      (tp_we),
        .we_bank (tp_bank),
        .we_addr (tp_addr),
        .we_word ({tp_data, tp_ecc}),
        .rd_bank (bank_cur),
        .rd_addr (ptr_cur),
        .rd_word (entry)
    );

    always_comb begin
        ctrl_view         = st_q.ctrl;
        ctrl_view[AW-1:0] = st_q.ptr;

        st_d     = st_q;
        st_d.ptr = ptr_nxt;
        if (acc.ctrl_we)
            st_d.ctrl = host_wdata;
        if (acc.any_re) begin
            st_d.rdata = '0;
            if (acc.ctrl_re)
                st_d.rdata = ctrl_view;
            else if (acc.data_re)
                st_d.rdata = entry[ECC_W +: DATA_W];
            else if (acc.ecc_re)
                st_d.rdata[ECC_W-1:0] = entry[ECC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
endmodule

// File: rtl/bufrd_port_chk.sv
module bufrd_port_chk #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        host_addr,
    input logic [AW-1:0]     load_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic [AW-1:0]     ptr_cur,
    input logic              step_cur
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic rd_ok;
    assign rd_ok = host_rd & ~host_wr;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == 2'd0 |=> ptr_cur == $past(load_addr));

    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok && host_addr == 2'd1 |=> $stable(ptr_cur));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok && host_addr == 2'd2 && step_cur && ptr_cur != LAST
        |=> ptr_cur == $past(ptr_cur) + AW'(1));

    p_ecc_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok && host_addr == 2'd2 |=> host_rdata[DATA_W-1:ECC_W] == '0);

    p_nostep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok && host_addr == 2'd2 && !step_cur |=> $stable(ptr_cur));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok && host_addr == 2'd2 && step_cur && ptr_cur == LAST |=> ptr_cur == '0);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(host_rdata));

    p_ignored_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr != 2'd0 |=> $stable(ptr_cur));
endmodule

bind bufrd_port bufrd_port_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ECC_W(ECC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .load_addr  (host_wdata[AW-1:0]),
    .host_rdata (host_rdata),
    .ptr_cur    (ptr_cur),
    .step_cur   (step_cur)
);

// File: tb/bufrd_port_test.sv
module bufrd_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 64;
    localparam int DATA_W = 64;
    localparam int ECC_W  = 8;
    localparam int AW     = $clog2(DEPTH);
    localparam logic [63:0] STEP = 64'h100;
    localparam logic [63:0] EGEN = 64'h200;
    localparam logic [63:0] BANK = 64'h1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [1:0]        host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              tp_we = 1'b0;
    logic              tp_bank = 1'b0;
    logic [AW-1:0]     tp_addr = '0;
    logic [DATA_W-1:0] tp_data = '0;
    logic [ECC_W-1:0]  tp_ecc = '0;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bufrd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ECC_W(ECC_W)) uut (
        .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
        .tp_we, .tp_bank, .tp_addr, .tp_data, .tp_ecc
    );

    function automatic logic [63:0] exp_data(int b, int i);
        return 64'hC0DE_0000_0000_0000 | (64'(b) << 44) | (64'(i) << 8) | 64'(8'(i) ^ 8'h5A);
    endfunction

    function automatic logic [63:0] exp_ecc(int b, int i);
        return 64'(8'(i * 5 + 1) ^ (b != 0 ? 8'hF0 : 8'h00));
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [1:0] off, logic [63:0] val);
        @(negedge clk);
        host_wr = 1'b1; host_addr = off; host_wdata = val;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(logic [1:0] off, output logic [63:0] val);
        @(negedge clk);
        host_rd = 1'b1; host_addr = off;
        @(negedge clk);
        host_rd = 1'b0;
        val = host_rdata;
    endtask

    task automatic preload();
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                @(negedge clk);
                tp_we = 1'b1; tp_bank = 1'(b); tp_addr = AW'(i);
                tp_data = exp_data(b, i); tp_ecc = ECC_W'(exp_ecc(b, i));
            end
        end
        @(negedge clk);
        tp_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R1 rdata after reset", host_rdata, 64'h0);
        host_read(2'd0, v);
        check("R1 ctrl after reset", v, 64'h0);
    endtask

    task automatic t_ctrl_readback();
        logic [63:0] v;
        host_write(2'd0, 64'hDEAD_0000_0000_0000 | BANK | EGEN | STEP | 64'd10);
        host_read(2'd0, v);
        check("R2 ctrl readback", v, 64'hDEAD_0000_0000_0000 | BANK | EGEN | STEP | 64'd10);
        host_write(2'd0, STEP | 64'd0);
        host_read(2'd0, v);
        check("R2 manual return to 0", v, STEP);
    endtask

    task automatic t_data_hold();
        logic [63:0] v;
        host_write(2'd0, STEP | 64'd5);
        host_read(2'd1, v);
        check("R3 data at 5", v, exp_data(0, 5));
        host_read(2'd1, v);
        check("R3 data repeat at 5", v, exp_data(0, 5));
        host_read(2'd0, v);
        check("R3 pointer unmoved", v, STEP | 64'd5);
    endtask

    task automatic t_walk();
        logic [63:0] v;
        host_write(2'd0, STEP | 64'd20);
        for (int k = 0; k < 4; k++) begin
            host_read(2'd1, v);
            check("R4 walk data", v, exp_data(0, 20 + k));
            host_read(2'd2, v);
            check("R4 walk ecc", v, exp_ecc(0, 20 + k));
        end
        host_read(2'd0, v);
        check("R4 pointer advanced", v, STEP | 64'd24);
    endtask

    task automatic t_nostep();
        logic [63:0] v;
        host_write(2'd0, 64'd7);
        for (int k = 0; k < 3; k++) begin
            host_read(2'd2, v);
            check("R5 ecc no step", v, exp_ecc(0, 7));
        end
        host_read(2'd0, v);
        check("R5 pointer held", v, 64'd7);
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        int idx [4] = '{62, 63, 0, 1};
        host_write(2'd0, STEP | 64'd62);
        for (int k = 0; k < 4; k++) begin
            host_read(2'd1, v);
            check("R6 wrap data", v, exp_data(0, idx[k]));
            host_read(2'd2, v);
            check("R6 wrap ecc", v, exp_ecc(0, idx[k]));
        end
        host_read(2'd0, v);
        check("R6 pointer after wrap", v, STEP | 64'd2);
    endtask

    task automatic t_bank();
        logic [63:0] v;
        host_write(2'd0, BANK | STEP | 64'd3);
        host_read(2'd1, v);
        check("R7 bank1 data", v, exp_data(1, 3));
        host_read(2'd2, v);
        check("R7 bank1 ecc", v, exp_ecc(1, 3));
        host_write(2'd0, STEP | 64'd3);
        host_read(2'd1, v);
        check("R7 bank0 data", v, exp_data(0, 3));
    endtask

    task automatic t_hold();
        logic [63:0] v;
        host_write(2'd0, STEP | 64'd40);
        host_read(2'd1, v);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 rdata holds", host_rdata, exp_data(0, 40));
        end
        host_write(2'd0, STEP | 64'd41);
        check("R8 rdata holds over write", host_rdata, exp_data(0, 40));
    endtask

    task automatic t_ignored();
        logic [63:0] v;
        host_write(2'd0, STEP | 64'd30);
        host_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        host_write(2'd2, 64'h0000_0000_0000_0011);
        host_read(2'd0, v);
        check("R9 pointer after ignored writes", v, STEP | 64'd30);
        host_read(2'd1, v);
        check("R9 data unchanged", v, exp_data(0, 30));
        host_read(2'd2, v);
        check("R9 ecc unchanged", v, exp_ecc(0, 30));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        preload();
        t_ctrl_readback();
        t_data_hold();
        t_walk();
        t_nostep();
        t_wrap();
        t_bank();
        t_hold();
        t_ignored();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule